// File: doc/BRIEF.md
# Tile-Mapped VGA Display Controller

This block produces a 640x480 VGA raster from a 50 MHz system clock and paints a 512x384 game window in the top-left corner of the visible frame. Picture content comes from a small internal tile map of 64 columns by 48 rows. Each entry holds a two-bit colour code, and every entry covers an 8x8 block of screen pixels. A four-entry palette turns the code into 3-bit red, 3-bit green and 2-bit blue drive.

A processor or test harness loads the tile map through a plain strobe port: chip select, write enable, address and code. The port answers every write with a one-cycle acknowledge. The display side runs on a divide-by-two pixel enable, so pixels arrive at 25 MHz. It keeps two raster counters, one for columns and one for lines. From the counters it slices the tile address, reads the map one pixel enable ahead and applies the palette. Sync and window signals are delayed by the same stage, so they stay aligned with the colour.

All timing figures, the window size, the tile size, the clock divide and the palette are parameters. The bench runs a reduced raster so that it can observe whole frames.

Top module: `tile_vga_display`

## Requirements
- R1: The pixel enable fires on every second system clock. hsync_n repeats every 800 pixels (1600 clocks) and is low for 96 pixels (192 clocks). Its fall comes 656 pixels after pixel 0 of a line.
- R2: vsync_n repeats every 525 lines (525 hsync periods) and is low for 2 whole lines. It falls at the start of pixel 0 of line 490.
- R3: While rst_n is low, and right after it, hsync_n and vsync_n are high (both syncs are active low), red, green and blue are zero, and wr_ack is low.
- R4: A window pixel at column x and line y shows the tile entry at address {y[8:3], x[8:3]}, which is (y/8)*64 + x/8. All 64 pixels of one 8x8 tile show the same entry.
- R5: The palette gives code 0 black (red 000, green 000, blue 00), code 1 yellow (111, 111, 00), code 2 blue (000, 000, 11) and code 3 red (111, 000, 00).
- R6: Red, green and blue are zero for x >= 512 or y >= 384, and during horizontal and vertical blanking.
- R7: A tile entry is written when wr_cs and wr_en are both high at a clock edge. wr_ack is then high for exactly the next cycle. With either strobe low, nothing is written and no acknowledge appears. Addresses at or above 3072 are dropped.
- R8: Colour and sync carry the same one-pixel pipeline delay. Pixel 0 of a line begins exactly 144 pixels (288 clocks) after hsync_n falls, and the clock just before it is black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_cs | input | 1 | Chip select of the tile-map write port |
| wr_en | input | 1 | Write strobe of the tile-map write port |
| wr_addr | input | 12 | Tile address {row, column} |
| wr_data | input | 2 | Colour code to store |
| wr_ack | output | 1 | One-cycle acknowledge of a write |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 3 | Red drive |
| green | output | 3 | Green drive |
| blue | output | 2 | Blue drive |

## Verification
Every display output changes one system clock after the pixel-enable edge that registers it. A pixel therefore occupies two clocks, starting on the clock after the edge that registers it. The bench anchors itself on each falling edge of vsync_n, which marks pixel 0 of the first sync line. From that point it counts exactly 2*(lines*H_TOTAL + x) falling clock edges to reach any pixel, and for boundary checks it samples the clock before as well. The write acknowledge is due one clock after the strobe and is checked on the following falling edge and on the one after that. Sync widths and periods are measured edge to edge in whole clocks.

// File: rtl/tvga_pkg.sv
package tvga_pkg;

   // One output colour: 3 bits red, 3 bits green, 2 bits blue.
   typedef struct packed {
      logic [2:0] r;
      logic [2:0] g;
      logic [1:0] b;
   } tvga_rgb_t;

   // Entry i sits at bits [8*i +: 8]: black, yellow, blue, red.
   localparam logic [31:0] DEFAULT_PALETTE = {
      8'b111_000_00,   // code 3: red
      8'b000_000_11,   // code 2: blue
      8'b111_111_00,   // code 1: yellow
      8'b000_000_00    // code 0: black
   };

endpackage

// File: rtl/tvga_pixel_tick.sv
module tvga_pixel_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic pix_en
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("tvga_pixel_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_full_rate
         logic unused_tick_inputs;
         assign unused_tick_inputs = clk ^ rst_n;
         assign pix_en = 1'b1;
      end else begin : g_divided
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase <= '0;
            else
               phase <= (phase == LAST) ? '0 : phase + 1'b1;
         end

         assign pix_en = (phase == LAST);
      end
   endgenerate

endmodule

// File: rtl/tvga_axis_counter.sv
module tvga_axis_counter #(
   parameter int ACTIVE = 640,
   parameter int FRONT  = 16,
   parameter int SYNC   = 96,
   parameter int BACK   = 48,
   localparam int TOTAL = ACTIVE + FRONT + SYNC + BACK,
   localparam int CW    = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [CW-1:0] count,
   output logic          last,
   output logic          in_sync
);

   localparam logic [CW-1:0] LAST_POS = CW'(TOTAL - 1);
   localparam logic [CW:0]   SYNC_LO  = (CW + 1)'(ACTIVE + FRONT);
   localparam logic [CW:0]   SYNC_HI  = (CW + 1)'(ACTIVE + FRONT + SYNC);

   generate
      if (ACTIVE < 1 || SYNC < 1 || FRONT < 0 || BACK < 0) begin : g_bad_timing
         $error("tvga_axis_counter: timing segments out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (step)
         count <= last ? '0 : count + 1'b1;
   end

   assign last    = (count == LAST_POS);
   assign in_sync = ({1'b0, count} >= SYNC_LO) && ({1'b0, count} < SYNC_HI);

endmodule

// File: rtl/tvga_tile_ram.sv
module tvga_tile_ram #(
   parameter int DEPTH = 3072,
   parameter int AW    = 12,
   parameter int DW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   generate
      if (DEPTH > (1 << AW) || DEPTH < 1) begin : g_bad_depth
         $error("tvga_tile_ram: DEPTH does not fit the address width");
      end
   endgenerate

   localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic          rd_ok;

   assign rd_ok = ({1'b0, rd_addr} < LIMIT);

   // Write side: one entry per acknowledged strobe.
   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   // Read side: registered, advances only on the pixel enable.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_ok ? mem[rd_addr] : '0;
   end

endmodule

// File: rtl/tile_vga_display.sv
module tile_vga_display
   import tvga_pkg::*;
#(
   parameter int H_ACTIVE    = 640,
   parameter int H_FRONT     = 16,
   parameter int H_SYNC      = 96,
   parameter int H_BACK      = 48,
   parameter int V_ACTIVE    = 480,
   parameter int V_FRONT     = 10,
   parameter int V_SYNC      = 2,
   parameter int V_BACK      = 33,
   parameter int WIN_W       = 512,
   parameter int WIN_H       = 384,
   parameter int TILE_LOG2   = 3,
   parameter int CLK_PER_PIX = 2,
   parameter int CODE_W      = 2,
   parameter logic [(8 << CODE_W)-1:0] PALETTE = DEFAULT_PALETTE,
   localparam int X_BITS = $clog2(WIN_W),
   localparam int Y_BITS = $clog2(WIN_H),
   localparam int COL_W  = X_BITS - TILE_LOG2,
   localparam int ROW_W  = Y_BITS - TILE_LOG2,
   localparam int TA_W   = COL_W + ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cs,
   input  logic              wr_en,
   input  logic [TA_W-1:0]   wr_addr,
   input  logic [CODE_W-1:0] wr_data,
   output logic              wr_ack,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic [2:0]        red,
   output logic [2:0]        green,
   output logic [1:0]        blue
);

   localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int HC_W    = $clog2(H_TOTAL);
   localparam int VC_W    = $clog2(V_TOTAL);
   localparam int PA_W    = X_BITS + Y_BITS;
   localparam int DEPTH   = (WIN_W * WIN_H) >> (2 * TILE_LOG2);
   localparam int NCOL    = 1 << CODE_W;

   localparam logic [HC_W:0] WIN_X_END = (HC_W + 1)'(WIN_W);
   localparam logic [VC_W:0] WIN_Y_END = (VC_W + 1)'(WIN_H);
   localparam logic [TA_W:0] MAP_END   = (TA_W + 1)'(DEPTH);

   // ---------------------------------------------------------------
   // Elaboration-time parameter checks
   // ---------------------------------------------------------------
   generate
      if ((1 << X_BITS) != WIN_W) begin : g_bad_win_w
         $error("tile_vga_display: WIN_W must be a power of two");
      end
      if (WIN_W > H_ACTIVE || WIN_H > V_ACTIVE) begin : g_bad_window
         $error("tile_vga_display: window larger than the visible frame");
      end
      if ((WIN_W % (1 << TILE_LOG2)) != 0 || (WIN_H % (1 << TILE_LOG2)) != 0) begin : g_bad_tile
         $error("tile_vga_display: window not a whole number of tiles");
      end
      if (COL_W < 1 || ROW_W < 1) begin : g_bad_map
         $error("tile_vga_display: tile map needs at least two rows and columns");
      end
      if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
         $error("tile_vga_display: CODE_W out of range");
      end
   endgenerate

   // ---------------------------------------------------------------
   // Pixel enable and raster counters
   // ---------------------------------------------------------------
   logic pix_en;

   tvga_pixel_tick #(
      .DIV (CLK_PER_PIX)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .pix_en (pix_en)
   );

   logic [HC_W-1:0] h_count;
   logic [VC_W-1:0] v_count;
   logic            h_last, v_last;
   logic            h_sync_on, v_sync_on;
   logic            line_step;

   assign line_step = pix_en & h_last;

   tvga_axis_counter #(
      .ACTIVE (H_ACTIVE),
      .FRONT  (H_FRONT),
      .SYNC   (H_SYNC),
      .BACK   (H_BACK)
   ) u_hcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (pix_en),
      .count   (h_count),
      .last    (h_last),
      .in_sync (h_sync_on)
   );

   tvga_axis_counter #(
      .ACTIVE (V_ACTIVE),
      .FRONT  (V_FRONT),
      .SYNC   (V_SYNC),
      .BACK   (V_BACK)
   ) u_vcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (line_step),
      .count   (v_count),
      .last    (v_last),
      .in_sync (v_sync_on)
   );

   // ---------------------------------------------------------------
   // Window test and tile address slicing
   // ---------------------------------------------------------------
   logic            in_win;
   logic [PA_W-1:0] pix_addr;
   logic [TA_W-1:0] rd_addr;

   assign in_win   = ({1'b0, h_count} < WIN_X_END) && ({1'b0, v_count} < WIN_Y_END);
   assign pix_addr = {v_count[Y_BITS-1:0], h_count[X_BITS-1:0]};
   // Keep the upper bits of the line and column fields; the low
   // TILE_LOG2 bits of each only pick a pixel inside a tile.
   assign rd_addr  = {pix_addr[PA_W-1 -: ROW_W], pix_addr[X_BITS-1 -: COL_W]};

   logic unused_raster_bits;
   assign unused_raster_bits = ^{pix_addr, h_count, v_count, v_last};

   // ---------------------------------------------------------------
   // Tile memory: write port from the strobe interface, read port
   // driven by the raster one pixel enable ahead of the outputs.
   // ---------------------------------------------------------------
   logic              wr_hit;
   logic              wr_store;
   logic [CODE_W-1:0] tile_code;

   assign wr_hit   = wr_cs & wr_en;
   assign wr_store = wr_hit & ({1'b0, wr_addr} < MAP_END);

   tvga_tile_ram #(
      .DEPTH (DEPTH),
      .AW    (TA_W),
      .DW    (CODE_W)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_store),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (pix_en),
      .rd_addr (rd_addr),
      .rd_data (tile_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_ack <= 1'b0;
      else
         wr_ack <= wr_hit;
   end

   // ---------------------------------------------------------------
   // Matching delay for window and sync, same stage as the read
   // ---------------------------------------------------------------
   logic win_q, hs_q, vs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         hs_q  <= 1'b0;
         vs_q  <= 1'b0;
      end else if (pix_en) begin
         win_q <= in_win;
         hs_q  <= h_sync_on;
         vs_q  <= v_sync_on;
      end
   end

   assign hsync_n = ~hs_q;
   assign vsync_n = ~vs_q;

   // ---------------------------------------------------------------
   // Palette
   // ---------------------------------------------------------------
   tvga_rgb_t pal [NCOL];
   tvga_rgb_t colour;

   generate
      for (genvar i = 0; i < NCOL; i++) begin : g_pal
         assign pal[i] = PALETTE[8*i +: 8];
      end
   endgenerate

   assign colour = win_q ? pal[tile_code] : '0;
   assign red    = colour.r;
   assign green  = colour.g;
   assign blue   = colour.b;

endmodule

// File: rtl/tvga_checker.sv
module tvga_checker #(
   parameter int HC_W    = 10,
   parameter int H_TOTAL = 800
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pix_en,
   input logic [HC_W-1:0] hcount,
   input logic            wr_cs,
   input logic            wr_en,
   input logic            wr_ack,
   input logic            hsync_n,
   input logic            vsync_n,
   input logic [2:0]      red,
   input logic [2:0]      green,
   input logic [1:0]      blue
);

   localparam logic [HC_W:0] H_LIMIT = (HC_W + 1)'(H_TOTAL);

   // R1: the column counter never leaves the line length
   assert_hcount_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, hcount} < H_LIMIT));

   // R1: display outputs only move on the clock after a pixel enable
   assert_sync_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_n != $past(hsync_n)) |-> $past(pix_en));

   // R2: vertical sync changes are also paced by the pixel enable
   assert_vsync_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync_n != $past(vsync_n)) |-> $past(pix_en));

   // R6: no colour while either sync pulse is active
   assert_blank_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync_n || !vsync_n) |-> ({red, green, blue} == 8'd0));

   // R7: a full strobe is acknowledged on the next cycle
   assert_ack_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cs && wr_en) |=> wr_ack);

   // R7: an acknowledge always has a strobe one cycle before it
   assert_ack_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |-> $past(wr_cs && wr_en));

endmodule

bind tile_vga_display tvga_checker #(
   .HC_W    (HC_W),
   .H_TOTAL (H_TOTAL)
) u_tvga_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .pix_en  (pix_en),
   .hcount  (h_count),
   .wr_cs   (wr_cs),
   .wr_en   (wr_en),
   .wr_ack  (wr_ack),
   .hsync_n (hsync_n),
   .vsync_n (vsync_n),
   .red     (red),
   .green   (green),
   .blue    (blue)
);

// File: tb/test_tile_vga_display.sv
`timescale 1ns/1ps
module test_tile_vga_display;

   // Reduced raster so that whole frames fit in the run.
   localparam int HA = 40, HF = 2, HS = 4, HB = 2;
   localparam int VA = 24, VF = 1, VS = 2, VB = 2;
   localparam int HT = HA + HF + HS + HB;   // 48 pixels per line
   localparam int VT = VA + VF + VS + VB;   // 29 lines per frame
   localparam int WW = 32, WH = 24;
   localparam int VLEAD = VS + VB;          // lines from vsync fall to line 0
   localparam int HLEAD = HS + HB;          // pixels from hsync fall to pixel 0
   localparam int AW = 4, CW = 2, NTILE = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_cs = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          wr_ack;
   logic          hsync_n, vsync_n;
   logic [2:0]    red, green;
   logic [1:0]    blue;

   int n_chk  = 0;
   int n_fail = 0;
   logic [CW-1:0] model [NTILE];

   always #2 clk = ~clk;   // 250 MHz

   tile_vga_display #(
      .H_ACTIVE (HA), .H_FRONT (HF), .H_SYNC (HS), .H_BACK (HB),
      .V_ACTIVE (VA), .V_FRONT (VF), .V_SYNC (VS), .V_BACK (VB),
      .WIN_W (WW), .WIN_H (WH)
   ) i_tile_vga_display (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cs   (wr_cs),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_ack  (wr_ack),
      .hsync_n (hsync_n),
      .vsync_n (vsync_n),
      .red     (red),
      .green   (green),
      .blue    (blue)
   );

   function automatic int pal(input int code);
      case (code & 3)
         0: return 8'b000_000_00;
         1: return 8'b111_111_00;
         2: return 8'b000_000_11;
         default: return 8'b111_000_00;
      endcase
   endfunction

   function automatic int expect_px(input int x, input int y);
      if (x >= WW || y >= WH) return 0;
      return pal(int'(model[(y / 8) * 4 + (x / 8)]));
   endfunction

   function automatic int px_off(input int x, input int y);
      return 2 * ((VLEAD + y) * HT + x);
   endfunction

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int rgb();
      return int'({red, green, blue});
   endfunction

   // Stops on the negedge that first shows vsync_n low.
   task automatic sync_frame();
      logic prev;
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (prev && !vsync_n) break;
         prev = vsync_n;
      end
   endtask

   task automatic sample_px(input int x, input int y, output int val);
      sync_frame();
      repeat (px_off(x, y)) @(negedge clk);
      val = rgb();
   endtask

   task automatic do_write(input int a, input int d, input logic cs, input logic en);
      @(negedge clk);
      wr_cs = cs; wr_en = en; wr_addr = AW'(a); wr_data = CW'(d);
      @(negedge clk);
      wr_cs = 1'b0; wr_en = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R3 hsync_n in reset", hsync_n, 1);
      check("R3 vsync_n in reset", vsync_n, 1);
      check("R3 colour in reset", rgb(), 0);
      check("R3 wr_ack in reset", wr_ack, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 hsync_n after reset", hsync_n, 1);
   endtask

   task automatic t_hsync();
      logic prev;
      int lo, per;
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (prev && !hsync_n) break;
         prev = hsync_n;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (hsync_n) break;
         lo++;
      end
      per = lo;
      forever begin
         per++;
         @(negedge clk);
         if (!hsync_n) break;
      end
      check("R1 hsync low clocks", lo, 2 * HS);
      check("R1 hsync period clocks", per, 2 * HT);
   endtask

   task automatic t_vsync();
      int lo, per;
      sync_frame();
      lo = 1;
      forever begin
         @(negedge clk);
         if (vsync_n) break;
         lo++;
      end
      per = lo;
      forever begin
         per++;
         @(negedge clk);
         if (!vsync_n) break;
      end
      check("R2 vsync low clocks", lo, 2 * VS * HT);
      check("R2 vsync period clocks", per, 2 * VT * HT);
   endtask

   task automatic t_write_ack();
      @(negedge clk);
      wr_cs = 1'b1; wr_en = 1'b1; wr_addr = 4'd5; wr_data = 2'd2;
      model[5] = 2'd2;
      @(negedge clk);
      wr_cs = 1'b0; wr_en = 1'b0;
      check("R7 ack one cycle after strobe", wr_ack, 1);
      @(negedge clk);
      check("R7 ack drops after one cycle", wr_ack, 0);
      do_write(5, 1, 1'b0, 1'b1);
      check("R7 no ack without chip select", wr_ack, 0);
      do_write(5, 3, 1'b1, 1'b0);
      check("R7 no ack without write enable", wr_ack, 0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < NTILE; a++) begin
         model[a] = CW'((a & 3) + (a >> 2));
         do_write(a, int'(model[a]), 1'b1, 1'b1);
      end
   endtask

   task automatic t_tiles();
      int v;
      int xs [8] = '{0, 7, 8, 15, 17, 24, 31, 3};
      int ys [8] = '{0, 7, 0, 7, 9, 16, 23, 20};
      for (int i = 0; i < 8; i++) begin
         sample_px(xs[i], ys[i], v);
         check($sformatf("R4 R5 pixel (%0d,%0d)", xs[i], ys[i]), v, expect_px(xs[i], ys[i]));
      end
   endtask

   task automatic t_outside();
      int v;
      sample_px(WW, 5, v);
      check("R6 first column past window", v, 0);
      sample_px(38, 12, v);
      check("R6 inside visible, right of window", v, 0);
      sample_px(4, WH, v);
      check("R6 line below window", v, 0);
      sample_px(HA + 3, 2, v);
      check("R6 horizontal blanking", v, 0);
      sample_px(10, VA + VF, v);
      check("R6 vertical blanking", v, 0);
   endtask

   task automatic t_ignored_write();
      int v;
      do_write(0, int'(model[0]) ^ 3, 1'b0, 1'b1);
      do_write(0, int'(model[0]) ^ 2, 1'b1, 1'b0);
      do_write(13, 3, 1'b1, 1'b1);
      sample_px(2, 2, v);
      check("R7 tile 0 unchanged after partial strobes", v, expect_px(2, 2));
      for (int a = 0; a < NTILE; a++) begin
         sample_px((a & 3) * 8 + 4, (a >> 2) * 8 + 4, v);
         check($sformatf("R7 tile %0d after dropped write", a), v, expect_px((a & 3) * 8 + 4, (a >> 2) * 8 + 4));
      end
   endtask

   task automatic t_align();
      int base;
      base = px_off(0, 8);
      sync_frame();
      repeat (base - 2 * HLEAD - 1) @(negedge clk);
      check("R8 hsync still high before fall", hsync_n, 1);
      @(negedge clk);
      check("R8 hsync falls 2*HLEAD clocks before pixel 0", hsync_n, 0);
      repeat (2 * HLEAD - 1) @(negedge clk);
      check("R8 black clock before pixel 0", rgb(), 0);
      @(negedge clk);
      check("R8 pixel 0 colour on time", rgb(), expect_px(0, 8));
      repeat (2 * (WW - 1) + 1) @(negedge clk);
      check("R8 last window pixel second clock", rgb(), expect_px(WW - 1, 8));
      @(negedge clk);
      check("R6 R8 window ends on time", rgb(), 0);
   endtask

   initial begin
      for (int a = 0; a < NTILE; a++) model[a] = '0;
      t_reset();
      t_hsync();
      t_vsync();
      t_write_ack();
      t_fill();
      t_tiles();
      t_outside();
      t_ignored_write();
      t_align();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule